// File: doc/BRIEF.md
# Timer/Counter and Watchdog with Shared Prescaler

This block holds an 8-bit timer/counter and a watchdog timer that take turns using one programmable prescaler. The timer counts either an internal tick, derived from the system clock divided by 2 or by 4, or edges on an external pin. The external pin is first passed through a two-flop synchronizer, and a programmable bit picks whether its rising or its falling edge counts. When the timer wraps from its all-ones value to zero, it sets a sticky overflow flag. Software reads the timer value directly on an output and writes it over a small register bus.

The watchdog runs from a separate free-running tick input, which stands in for an on-chip RC oscillator. Its base counter is parameterized and 16 bits wide by default. One control bit decides which unit gets the prescaler; the other unit then runs undivided. While the watchdog is enabled, a timeout asserts a reset request. This happens in sleep too, because sleep halts only the timer's internal tick. Software can enable or disable the watchdog at any time, and a clear strobe restarts it.

The watchdog sequencer has three states. `WD_OFF` means the enable bit is clear. `WD_RUN` means the watchdog is counting. `WD_TRIP` means the reset request is asserted. Its transitions are:

| From | To | Condition |
|---|---|---|
| `WD_OFF` | `WD_RUN` | the enable bit is set |
| `WD_RUN` | `WD_TRIP` | timeout |
| `WD_RUN` | `WD_OFF` | enable cleared |
| `WD_TRIP` | `WD_RUN` | clear strobe |
| `WD_TRIP` | `WD_OFF` | enable cleared |

Top module: `tmr_wdog_unit`

## Requirements
- R1: Register bus address map:
  - Address 0 is the timer value.
  - Address 1 is the control byte:
    - bits [2:0]: prescaler select `sel`.
    - bit 3: prescaler to watchdog when 1.
    - bit 4: external source when 1.
    - bit 5: count falling edges when 1.
    - bit 6: divide-by-4 internal tick when 1.
    - bit 7: watchdog enable.
  - A write of any data to address 2 clears the overflow flag.

  After reset, the timer value is 0, the flag is 0, the reset request is 0, and the control byte is 0.
- R2: With the internal source and no prescaler, the timer advances exactly once every 2 clock cycles, or once every 4 when bit 6 is 1.
- R3: With the external source, the timer advances once per rising pin edge (bit 5 = 0) or once per falling pin edge (bit 5 = 1). The increment is visible after the third clock edge that follows the pin change. The opposite edge is ignored.
- R4: With the prescaler on the timer, the timer advances once per 2^(sel+1) source events.
- R5: A write to address 0 loads the timer on the next edge and takes precedence over an increment in the same cycle. While the prescaler is on the timer, that write also clears the prescaler.
- R6: An increment from 0xFF to 0x00 sets the overflow flag. The flag stays set until a write to address 2. A wrap in the same cycle as that write leaves the flag set.
- R7: With the watchdog enabled and no prescaler, the reset request rises 2^WDT_W watchdog ticks after enable or after the last clear.
- R8: After a timeout, the reset request stays asserted until a clear strobe or a disable.
- R9: While the watchdog is disabled, its counter stays at zero and the reset request stays low.
- R10: The clear strobe zeroes the watchdog counter, and also zeroes the prescaler when the prescaler is on the watchdog.
- R11: With the prescaler on the watchdog, timeout takes 2^WDT_W × 2^(sel+1) ticks, and the timer counts undivided.
- R12: The sleep input halts the internal timer tick. The watchdog and the external source keep counting during sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| rst_n | input | 1 | Active-low reset |
| sleep_i | input | 1 | Sleep mode; halts the internal timer tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 timer, 1 control, 2 clear flag) |
| wr_data_i | input | DATA_W | Write data |
| ext_clk_i | input | 1 | External timer clock pin (asynchronous) |
| wdt_tick_i | input | 1 | Free-running watchdog tick, one clock cycle wide |
| wdt_clr_i | input | 1 | Clear-watchdog strobe |
| tmr_value_o | output | DATA_W | Current timer value |
| tmr_ovf_o | output | 1 | Timer overflow flag |
| wdt_rst_req_o | output | 1 | Watchdog reset request |

## Verification
The assertions check the following on every cycle:
- a timer write loads the written value,
- a wrap lands on zero with the flag set,
- a prescaler clear empties it,
- a timeout in `WD_RUN` raises the request, which then holds until cleared,
- a disabled watchdog never requests reset,
- the timer stays frozen in sleep when its source is the undivided internal tick.

Only the bench scenarios can show the counting ratios over many cycles:
- the divide-by-2 and divide-by-4 rates,
- the 2^(sel+1) prescaled rate,
- the three-edge latency of the synchronized pin,
- the tick counts until a watchdog timeout with and without the prescaler, including during sleep.

A cycle-accurate bench model compares all outputs throughout the random phase.

// File: rtl/tmr_wdog_pkg.sv
package tmr_wdog_pkg;

    localparam int PS_SEL_W = 3;

    // Control byte, bit 7 first
    typedef struct packed {
        logic                wdt_en;
        logic                div4;
        logic                edge_fall;
        logic                src_ext;
        logic                ps_to_wdt;
        logic [PS_SEL_W-1:0] ps_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_TRIP = 2'd2
    } wd_state_e;

    localparam logic [1:0] ADDR_TMR  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_FLAG = 2'd2;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic edge_o
);
    // chain[STAGES-1:0] synchronize, chain[STAGES] remembers the previous sample
    logic [STAGES:0] chain;
    logic            rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], pin_i};
    end

    always_comb begin
        rise   = chain[STAGES-1] & ~chain[STAGES];
        fall   = ~chain[STAGES-1] & chain[STAGES];
        edge_o = fall_sel_i ? fall : rise;
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = 3,
    localparam int W    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             evt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             evt_o
);
    logic [W-1:0] cnt;
    logic [W-1:0] mask;

    // Low sel+1 bits all ones marks the last input of each divided period
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign mask[i] = (SEL_W'(i) <= sel_i);
    end

    assign evt_o = evt_i && ((cnt & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clr_i) cnt <= '0;
        else if (evt_i) cnt <= cnt + 1'b1;
    end

    // R4 / R5 / R10: a clear always leaves the prescaler empty
    a_r10_ps_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt == '0));

endmodule

// File: rtl/tmr_wdog_fsm.sv
module tmr_wdog_fsm
    import tmr_wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic clr_i,
    input  logic timeout_i,
    output logic base_evt_o,
    output logic rst_req_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    wd_state_e        state, state_n;

    assign base_evt_o = en_i && !clr_i && tick_i && (cnt == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (!en_i || clr_i)  cnt <= '0;
        else if (tick_i)          cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            WD_OFF:  if (en_i) state_n = WD_RUN;
            WD_RUN:  if (!en_i) state_n = WD_OFF;
                     else if (timeout_i) state_n = WD_TRIP;
            WD_TRIP: if (!en_i) state_n = WD_OFF;
                     else if (clr_i) state_n = WD_RUN;
            default: state_n = WD_OFF;
        endcase
    end

    always_comb begin
        rst_req_o = (state == WD_TRIP);
    end

    // R7 / R11: a timeout seen while running raises the request next cycle
    a_r7_timeout_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN && en_i && timeout_i) |=> rst_req_o);
    // R8: the request holds until clear or disable
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o && en_i && !clr_i) |=> rst_req_o);
    // R9: disabled watchdog never requests reset
    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rst_req_o);
    // R10: clear or disable zeroes the base counter
    a_r10_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || !en_i) |=> (cnt == '0));

endmodule

// File: rtl/tmr_wdog_unit.sv
module tmr_wdog_unit
    import tmr_wdog_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int WDT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              ext_clk_i,
    input  logic              wdt_tick_i,
    input  logic              wdt_clr_i,
    output logic [DATA_W-1:0] tmr_value_o,
    output logic              tmr_ovf_o,
    output logic              wdt_rst_req_o
);
    localparam logic [DATA_W-1:0] TMR_MAX = '1;
    localparam int                CTRL_W  = $bits(ctrl_t);

    ctrl_t             ctrl;
    logic [1:0]        div_cnt;
    logic [DATA_W-1:0] tmr_q;
    logic              ovf_q;
    logic              wr_tmr, wr_ctrl, wr_flag;
    logic              int_tick, ext_evt, src_evt;
    logic              wd_base, ps_in, ps_out, ps_clr;
    logic              tmr_inc, wd_timeout;

    always_comb begin
        wr_tmr   = wr_en_i && (wr_addr_i == ADDR_TMR);
        wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_CTRL);
        wr_flag  = wr_en_i && (wr_addr_i == ADDR_FLAG);
        int_tick = !sleep_i && (ctrl.div4 ? (&div_cnt) : div_cnt[0]);
        src_evt  = ctrl.src_ext ? ext_evt : int_tick;
        // Prescaler routing: the unit not owning it bypasses it
        ps_in      = ctrl.ps_to_wdt ? wd_base : src_evt;
        ps_clr     = ctrl.ps_to_wdt ? wdt_clr_i : wr_tmr;
        tmr_inc    = ctrl.ps_to_wdt ? src_evt : ps_out;
        wd_timeout = ctrl.ps_to_wdt ? ps_out : wd_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            if (wr_ctrl) ctrl <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (wr_tmr)       tmr_q <= wr_data_i;
            else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
            if (tmr_inc && !wr_tmr && tmr_q == TMR_MAX) ovf_q <= 1'b1;
            else if (wr_flag)                            ovf_q <= 1'b0;
        end
    end

    assign tmr_value_o = tmr_q;
    assign tmr_ovf_o   = ovf_q;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_clk_i),
        .fall_sel_i (ctrl.edge_fall),
        .edge_o     (ext_evt)
    );

    tmr_prescaler #(.SEL_W(PS_SEL_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ps_clr),
        .evt_i (ps_in),
        .sel_i (ctrl.ps_sel),
        .evt_o (ps_out)
    );

    tmr_wdog_fsm #(.CNT_W(WDT_W)) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl.wdt_en),
        .tick_i     (wdt_tick_i),
        .clr_i      (wdt_clr_i),
        .timeout_i  (wd_timeout),
        .base_evt_o (wd_base),
        .rst_req_o  (wdt_rst_req_o)
    );

    // R5: a timer write loads the bus value
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tmr |=> (tmr_value_o == $past(wr_data_i)));
    // R6: wrap lands on zero with the flag set
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_inc && !wr_tmr && tmr_value_o == TMR_MAX) |=> (tmr_value_o == '0 && tmr_ovf_o));
    // R12: undivided internal source is frozen in sleep
    a_r12_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && !ctrl.src_ext && ctrl.ps_to_wdt && !wr_tmr) |=> $stable(tmr_value_o));

endmodule

// File: tb/tmr_wdog_unit_bench.sv
module tmr_wdog_unit_bench;
    localparam int BW = 4;               // short watchdog for the bench
    localparam logic [BW-1:0] BMAX = '1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep = 1'b0, wr_en = 1'b0, ext_pin = 1'b0, wtick = 1'b0, wclr = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] tmr_value;
    logic       tmr_ovf, rst_req;

    int  n_checks = 0, n_errors = 0;
    int  cycles = 0;
    bit  done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [1:0]    m_div;
    logic [2:0]    m_s;
    logic [7:0]    m_ps, m_tmr, m_ctrl;
    logic [BW-1:0] m_wc;
    logic          m_ovf;
    int            m_state;   // 0 off, 1 run, 2 trip

    always #4 clk = ~clk;

    tmr_wdog_unit #(.DATA_W(8), .WDT_W(BW), .SYNC_STAGES(2)) u_tmr_wdog_unit (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .ext_clk_i(ext_pin), .wdt_tick_i(wtick), .wdt_clr_i(wclr),
        .tmr_value_o(tmr_value), .tmr_ovf_o(tmr_ovf), .wdt_rst_req_o(rst_req)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            if (n_errors < 20)
                $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_div = 0; m_s = 0; m_ps = 0; m_tmr = 0; m_ctrl = 0; m_wc = 0; m_ovf = 0; m_state = 0;
    endtask

    task automatic model_step();
        logic wr0, wr1, wr2, it, ee, src, base, psin, psout, psclr, inc, to, en;
        logic [7:0] mask;
        wr0 = wr_en && wr_addr == 2'd0;
        wr1 = wr_en && wr_addr == 2'd1;
        wr2 = wr_en && wr_addr == 2'd2;
        en  = m_ctrl[7];
        it  = !sleep && (m_ctrl[6] ? (m_div == 2'd3) : m_div[0]);
        ee  = m_ctrl[5] ? (!m_s[1] && m_s[2]) : (m_s[1] && !m_s[2]);
        src = m_ctrl[4] ? ee : it;
        base = en && !wclr && wtick && (m_wc == BMAX);
        psin = m_ctrl[3] ? base : src;
        mask = 8'((9'd2 << m_ctrl[2:0]) - 9'd1);
        psout = psin && ((m_ps & mask) == mask);
        psclr = m_ctrl[3] ? wclr : wr0;
        inc = m_ctrl[3] ? src : psout;
        to  = m_ctrl[3] ? psout : base;
        case (m_state)
            0: if (en) m_state = 1;
            1: if (!en) m_state = 0; else if (to) m_state = 2;
            default: if (!en) m_state = 0; else if (wclr) m_state = 1;
        endcase
        if (inc && !wr0 && m_tmr == 8'hFF) m_ovf = 1; else if (wr2) m_ovf = 0;
        if (wr0) m_tmr = wr_data; else if (inc) m_tmr = m_tmr + 8'd1;
        if (psclr) m_ps = 0; else if (psin) m_ps = m_ps + 8'd1;
        if (!en || wclr) m_wc = 0; else if (wtick) m_wc = m_wc + 1'b1;
        m_s = {m_s[1:0], ext_pin};
        m_div = m_div + 2'd1;
        if (wr1) m_ctrl = wr_data;
    endtask

    // one clock cycle: model advances with the driven inputs, outputs compared after the edge
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({cur_req, " timer value"}, int'(tmr_value), int'(m_tmr));
        chk({cur_req, " overflow flag"}, int'(tmr_ovf), int'(m_ovf));
        chk({cur_req, " reset request"}, int'(rst_req), (m_state == 2) ? 1 : 0);
    endtask

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic cycles_to_req(int limit, output int n);
        n = 0;
        while (!rst_req && n < limit) begin
            cyc();
            n++;
        end
    endtask

    initial begin
        int v0, n;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 reset timer", int'(tmr_value), 0);
        chk("R1 reset flag", int'(tmr_ovf), 0);
        chk("R1 reset request", int'(rst_req), 0);

        // R2 internal source, undivided (prescaler on watchdog, watchdog off)
        cur_req = "R2";
        bus_wr(2'd1, 8'h08);
        bus_wr(2'd0, 8'h00);
        v0 = int'(tmr_value);
        run(40);
        chk("R2 div2 rate", int'(tmr_value) - v0, 20);
        bus_wr(2'd1, 8'h48);
        v0 = int'(tmr_value);
        run(40);
        chk("R2 div4 rate", int'(tmr_value) - v0, 10);

        // R12 sleep halts the internal tick
        cur_req = "R12";
        sleep = 1'b1;
        v0 = int'(tmr_value);
        run(40);
        chk("R12 sleep holds timer", int'(tmr_value), v0);
        sleep = 1'b0;

        // R3 external rising then falling edge
        cur_req = "R3";
        bus_wr(2'd1, 8'h18);
        run(4);
        v0 = int'(tmr_value);
        ext_pin = 1'b1;
        run(2);
        chk("R3 no count before third edge", int'(tmr_value), v0);
        cyc();
        chk("R3 rising counted", int'(tmr_value), v0 + 1);
        ext_pin = 1'b0;
        run(5);
        chk("R3 falling ignored in rising mode", int'(tmr_value), v0 + 1);
        bus_wr(2'd1, 8'h38);
        ext_pin = 1'b1;
        run(5);
        chk("R3 rising ignored in falling mode", int'(tmr_value), v0 + 1);
        ext_pin = 1'b0;
        run(3);
        chk("R3 falling counted", int'(tmr_value), v0 + 2);

        // R4 prescaler on timer, divide by 8 of div2 ticks
        cur_req = "R4";
        bus_wr(2'd1, 8'h02);
        bus_wr(2'd0, 8'h00);
        run(160);
        chk("R4 prescaled rate", int'(tmr_value), 10);

        // R5 write load
        cur_req = "R5";
        bus_wr(2'd0, 8'h5A);
        chk("R5 load value", int'(tmr_value), 8'h5A);

        // R6 overflow and flag clear
        cur_req = "R6";
        bus_wr(2'd1, 8'h08);
        bus_wr(2'd0, 8'hFE);
        run(5);
        chk("R6 flag after wrap", int'(tmr_ovf), 1);
        chk("R6 wrapped value", int'(tmr_value) < 3 ? 1 : 0, 1);
        bus_wr(2'd2, 8'h00);
        chk("R6 flag cleared", int'(tmr_ovf), 0);

        // R7 watchdog undivided timeout
        cur_req = "R7";
        wtick = 1'b1;
        bus_wr(2'd1, 8'h80);
        cycles_to_req(200, n);
        chk("R7 ticks to timeout", n, 16);

        // R8 request holds, then clear
        cur_req = "R8";
        wtick = 1'b0;
        run(4);
        chk("R8 request held", int'(rst_req), 1);
        wclr = 1'b1; cyc(); wclr = 1'b0;
        chk("R8 clear drops request", int'(rst_req), 0);

        // R10 clear restarts count
        cur_req = "R10";
        wtick = 1'b1;
        run(10);
        wclr = 1'b1; cyc(); wclr = 1'b0;
        run(12);
        chk("R10 no timeout after clear", int'(rst_req), 0);

        // R9 disabled watchdog quiet
        cur_req = "R9";
        bus_wr(2'd1, 8'h00);
        run(60);
        chk("R9 disabled no request", int'(rst_req), 0);

        // R11 prescaler on watchdog, divide by 4
        cur_req = "R11";
        bus_wr(2'd1, 8'h89);
        wclr = 1'b1; cyc(); wclr = 1'b0;
        v0 = int'(tmr_value);
        cycles_to_req(400, n);
        chk("R11 ticks to prescaled timeout", n, 64);
        chk("R11 timer undivided", int'(tmr_value) - v0, 32);

        // R12 watchdog runs in sleep
        cur_req = "R12";
        bus_wr(2'd1, 8'h80);
        sleep = 1'b1;
        wclr = 1'b1; cyc(); wclr = 1'b0;
        cycles_to_req(200, n);
        chk("R12 timeout during sleep", n, 16);
        sleep = 1'b0;

        // Random phase against the model
        cur_req = "random R4 R5 R6 R11";
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            wtick = ($urandom_range(0, 1) == 1);
            wclr  = ($urandom_range(0, 99) < 3);
            if ($urandom_range(0, 9) < 3) ext_pin = ~ext_pin;
            if ($urandom_range(0, 99) < 2) sleep = ~sleep;
            wr_en = 1'b0;
            if (r < 2) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'($urandom());
            end else if (r < 4) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'($urandom());
            end else if (r < 6) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'($urandom());
            end
            cyc();
        end
        wr_en = 1'b0; wclr = 1'b0;
        finish_run();
    end

endmodule